// File: doc/BRIEF.md
# I2C Channel Select Controller

This block is a serial-bus slave that owns a small channel-enable register. Each of the register's low bits switches one downstream bus segment on, and any mix of segments, including none or all four, can be on at the same time. A bus master sets the enables by addressing the block and writing a byte. It can read the register back at any time.

The SCL and SDA pins are first brought into the system clock domain and cleaned of short spikes. The protocol engine then finds START and STOP conditions, compares the address byte with a fixed upper part and three strap-pin bits, and acknowledges a match by pulling SDA low. SDA is only ever pulled low; it is never driven high. A written byte is staged in the engine and only reaches the enable outputs when the STOP that closes the write arrives. Two resets clear the register and abort any transfer: the synchronous system reset, which stands in for power-on, and a separate active-low bus reset pin.

Top module: `i2c_chan_select`

## Requirements
- R1: After system reset, `chan_en` is 4'b0000 and `sda_drive_low` is 0.
- R2: The slave acknowledges (holds SDA low in the ninth clock) only the address byte {4'b1110, strap[2:0], rw}, where rw = 0 means write and rw = 1 means read. Any other address gets no acknowledge and has no effect on `chan_en`.
- R3: Bits [3:0] of a written byte drive `chan_en[3:0]`, where bit n enables channel n. The new value appears only after the STOP that ends the write, not after that byte's acknowledge.
- R4: When a write carries several data bytes, every byte is acknowledged and the last complete byte is the value kept.
- R5: Bits [7:4] of a written byte are ignored, and they read back as zero.
- R6: A read returns the committed register as one byte, MSB first, and every byte the master acknowledges repeats it.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START.
- R8: While `bus_rst_n` is low, `chan_en` is cleared and any transfer in progress, including an acknowledge being driven, is abandoned, so SDA is released and the staged byte is never committed.
- R9: A repeated START in the middle of a byte restarts address matching. A STOP in the middle of a byte drops the partial byte and commits the last complete byte.
- R10: Any combination of the four channels (for example 4'b0101 or 4'b1111) can be enabled at once.
- R11: The slave only begins pulling SDA low while the filtered SCL is low.
- R12: A pulse on SCL or SDA that lasts a single clock cycle is filtered out. It does not count as a bit, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system (power-on) reset |
| bus_rst_n | input | 1 | Active-low bus reset; clears the register and aborts the transfer |
| strap | input | 3 | Low three address bits |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| sda_drive_low | output | 1 | When 1, the open-drain pad pulls SDA low |
| chan_en | output | 4 | Per-channel enables for the downstream segments |

## Verification
The active-low bus reset can arrive in the same cycle in which the engine is holding its acknowledge on SDA for a data byte that is staged but not yet committed. The bench provokes this by asserting the bus reset while SCL is high during the ninth clock of a write. It then requires SDA to be released at once and `chan_en` to read zero. The bench finishes the clock pulse and sends the STOP, and checks that the staged byte never reaches the enables. A related overlap is a STOP arriving mid-byte with a byte already staged. The bench judges that case by checking that the last full byte, not the fragment, becomes the enable value.

// File: rtl/i2c_cs_pkg.sv
package i2c_cs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } cs_state_t;
endpackage

// File: rtl/i2c_cs_glitch_filter.sv
module i2c_cs_glitch_filter #(
  parameter int LINES       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int TAPS        = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] line_in,
  output logic [LINES-1:0] line_out
);
  localparam int HALF = TAPS / 2;

  function automatic logic majority(input logic [TAPS-1:0] w);
    int ones;
    ones = 0;
    for (int i = 0; i < TAPS; i++) ones += int'(w[i]);
    return ones > HALF;
  endfunction

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sync_q;
    logic [TAPS-1:0]        win_q;
    logic                   out_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '1;
        win_q  <= '1;
        out_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in[g]};
        win_q  <= {win_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
        out_q  <= majority(win_q);
      end
    end

    assign line_out[g] = out_q;
  end
endmodule

// File: rtl/i2c_cs_engine.sv
module i2c_cs_engine
  import i2c_cs_pkg::*;
#(
  parameter int                  ADDR_HI_W = 4,
  parameter logic [ADDR_HI_W-1:0] ADDR_HI  = 4'b1110,
  parameter int                  STRAP_W   = 3,
  parameter int                  REG_W     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_f,
  input  logic               sda_f,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rd_byte,
  output logic               sda_drive_low,
  output logic               commit,
  output logic [REG_W-1:0]   wr_data
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  cs_state_t          state;
  logic [CNT_W-1:0]   bitcnt;
  logic [BYTE_W-1:0]  rx_q;
  logic [BYTE_W-1:0]  tx_q;
  logic               rw_q;
  logic               pending_q;
  logic               scl_q, sda_q;
  logic               scl_rise, scl_fall, start_c, stop_c, addr_hit;

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;
  assign addr_hit = (rx_q[BYTE_W-1:1] == {ADDR_HI, strap});

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      bitcnt        <= '0;
      rx_q          <= '0;
      tx_q          <= '0;
      rw_q          <= 1'b0;
      pending_q     <= 1'b0;
      scl_q         <= 1'b1;
      sda_q         <= 1'b1;
      sda_drive_low <= 1'b0;
      commit        <= 1'b0;
      wr_data       <= '0;
    end else begin
      scl_q  <= scl_f;
      sda_q  <= sda_f;
      commit <= 1'b0;
      if (stop_c) begin
        state         <= ST_IDLE;
        sda_drive_low <= 1'b0;
        if (pending_q) begin
          commit    <= 1'b1;
          pending_q <= 1'b0;
        end
      end else if (start_c) begin
        state         <= ST_ADDR;
        bitcnt        <= '0;
        sda_drive_low <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise) begin
              rx_q   <= {rx_q[BYTE_W-2:0], sda_f};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              if (state == ST_WDATA) begin
                wr_data       <= rx_q[REG_W-1:0];
                pending_q     <= 1'b1;
                sda_drive_low <= 1'b1;
                state         <= ST_WACK;
              end else if (addr_hit) begin
                rw_q          <= rx_q[0];
                sda_drive_low <= 1'b1;
                state         <= ST_AACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw_q) begin
                tx_q          <= rd_byte;
                sda_drive_low <= ~rd_byte[BYTE_W-1];
                state         <= ST_RDATA;
              end else begin
                sda_drive_low <= 1'b0;
                state         <= ST_WDATA;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_drive_low <= 1'b0;
              bitcnt        <= '0;
              state         <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == LAST_BIT) begin
                sda_drive_low <= 1'b0;
                state         <= ST_RACK;
              end else begin
                tx_q          <= {tx_q[BYTE_W-2:0], 1'b0};
                sda_drive_low <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise && sda_f) begin
              state <= ST_IDLE;
            end else if (scl_fall) begin
              tx_q          <= rd_byte;
              sda_drive_low <= ~rd_byte[BYTE_W-1];
              bitcnt        <= '0;
              state         <= ST_RDATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: a new pull-down begins only while filtered SCL is low
  p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive_low) |-> !$past(scl_f));

  // R7: master not-acknowledge during a read releases the line and idles
  p_nack_release_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RACK && scl_rise && sda_f && !start_c && !stop_c)
      |=> (state == ST_IDLE && !sda_drive_low));

  // R2: an address byte that does not match leaves the line released
  p_no_ack_mismatch_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR && scl_fall && bitcnt == LAST_BIT && !addr_hit && !start_c && !stop_c)
      |=> !sda_drive_low);
endmodule

// File: rtl/i2c_chan_select.sv
module i2c_chan_select
  import i2c_cs_pkg::*;
#(
  parameter int N_CHAN      = 4,
  parameter int STRAP_W     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_rst_n,
  input  logic [STRAP_W-1:0] strap,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_drive_low,
  output logic [N_CHAN-1:0]  chan_en
);
  localparam int ADDR_HI_W = 7 - STRAP_W;
  localparam logic [ADDR_HI_W-1:0] ADDR_HI = ADDR_HI_W'(4'b1110 >> STRAP_W - 3);

  logic [1:0]        line_f;
  logic [1:0]        brst_sync;
  logic              core_rst;
  logic              commit;
  logic [N_CHAN-1:0] wr_data;
  logic [N_CHAN-1:0] chan_q;
  logic [BYTE_W-1:0] rd_byte;

  i2c_cs_glitch_filter #(
    .LINES(2), .SYNC_STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)
  ) u_filter (
    .clk(clk), .rst(rst), .line_in({sda_in, scl_in}), .line_out(line_f)
  );

  always_ff @(posedge clk) begin
    if (rst) brst_sync <= 2'b11;
    else     brst_sync <= {brst_sync[0], bus_rst_n};
  end

  assign core_rst = rst | ~brst_sync[1];

  i2c_cs_engine #(
    .ADDR_HI_W(ADDR_HI_W), .ADDR_HI(ADDR_HI), .STRAP_W(STRAP_W), .REG_W(N_CHAN)
  ) u_engine (
    .clk(clk), .rst(core_rst), .scl_f(line_f[0]), .sda_f(line_f[1]),
    .strap(strap), .rd_byte(rd_byte), .sda_drive_low(sda_drive_low),
    .commit(commit), .wr_data(wr_data)
  );

  always_ff @(posedge clk) begin
    if (core_rst)    chan_q <= '0;
    else if (commit) chan_q <= wr_data;
  end

  assign rd_byte = {{(BYTE_W - N_CHAN){1'b0}}, chan_q};
  assign chan_en = chan_q;

  // R3: the enables change only on a commit produced by STOP, or by reset
  p_commit_at_stop_r3: assert property (@(posedge clk) disable iff (rst)
    (chan_en != $past(chan_en)) |-> ($past(commit) || $past(core_rst)));

  // R8: an active reset leaves enables clear and SDA released
  p_reset_outputs_r8: assert property (@(posedge clk) disable iff (rst)
    core_rst |=> (chan_en == '0 && !sda_drive_low));
endmodule

// File: tb/test_i2c_chan_select.sv
module test_i2c_chan_select;
  localparam int Q = 25;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_rst_n = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_drive_low;
  logic [3:0] chan_en;
  logic       sda_line;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_drive_low;

  i2c_chan_select i_i2c_chan_select (
    .clk(clk), .rst(rst), .bus_rst_n(bus_rst_n), .strap(strap),
    .scl_in(scl_m), .sda_in(sda_line),
    .sda_drive_low(sda_drive_low), .chan_en(chan_en)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1; wait_clk(Q); scl_m = 1; wait_clk(Q);
    sda_m = 0; wait_clk(Q); scl_m = 0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wait_clk(Q); scl_m = 1; wait_clk(Q);
    sda_m = 1; wait_clk(2 * Q);
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; wait_clk(Q); scl_m = 1; wait_clk(2 * Q); scl_m = 0; wait_clk(Q);
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1; wait_clk(Q); scl_m = 1; wait_clk(Q);
    b = sda_line; wait_clk(Q); scl_m = 0; wait_clk(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(s);
    acked = !s;
  endtask

  task automatic get_byte(output logic [7:0] v, input bit master_nack);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      get_bit(s);
      v[i] = s;
    end
    put_bit(master_nack);
    sda_m = 1;
  endtask

  function automatic logic [7:0] addr_byte(input logic [2:0] st, input bit rd);
    return {4'b1110, st, rd};
  endfunction

  task automatic write_reg(input logic [7:0] v);
    bit a;
    bus_start();
    put_byte(addr_byte(strap, 0), a);
    put_byte(v, a);
    bus_stop();
    wait_clk(10);
  endtask

  task automatic t_reset();
    check(chan_en == 4'h0, "R1 enables after reset", chan_en, 0);
    check(!sda_drive_low, "R1 sda released after reset", sda_drive_low, 0);
  endtask

  task automatic t_single_write();
    bit a;
    bus_start();
    put_byte(addr_byte(strap, 0), a);
    check(a, "R2 address acknowledged", a, 1);
    put_byte(8'h05, a);
    check(a, "R3 data acknowledged", a, 1);
    check(chan_en == 4'h0, "R3 no effect before STOP", chan_en, 0);
    bus_stop();
    wait_clk(10);
    check(chan_en == 4'h5, "R3 R10 enables 0101 after STOP", chan_en, 5);
  endtask

  task automatic t_multi_write();
    bit a0, a1, a2;
    bus_start();
    put_byte(addr_byte(strap, 0), a0);
    put_byte(8'h03, a0);
    put_byte(8'h0F, a1);
    put_byte(8'h0A, a2);
    check(a0 && a1 && a2, "R4 every byte acknowledged", {a0, a1, a2}, 7);
    bus_stop();
    wait_clk(10);
    check(chan_en == 4'hA, "R4 last byte kept", chan_en, 4'hA);
  endtask

  task automatic t_upper_bits();
    bit a;
    logic [7:0] v;
    write_reg(8'hF6);
    check(chan_en == 4'h6, "R5 upper bits ignored on write", chan_en, 6);
    bus_start();
    put_byte(addr_byte(strap, 1), a);
    check(a, "R6 read address acknowledged", a, 1);
    get_byte(v, 1);
    bus_stop();
    check(v == 8'h06, "R5 R6 readback with upper zero", v, 8'h06);
  endtask

  task automatic t_address_strap();
    bit a;
    logic [2:0] old;
    old = strap;
    write_reg(8'h09);
    bus_start();
    put_byte(addr_byte(3'b100, 0), a);
    check(!a, "R2 wrong address not acknowledged", a, 0);
    put_byte(8'h0F, a);
    check(!a, "R2 data ignored after mismatch", a, 0);
    bus_stop();
    wait_clk(10);
    check(chan_en == 4'h9, "R2 enables unchanged by mismatch", chan_en, 9);
    strap = 3'b010;
    wait_clk(10);
    bus_start();
    put_byte(addr_byte(3'b010, 0), a);
    check(a, "R2 new strap value acknowledged", a, 1);
    put_byte(8'h0E, a);
    bus_stop();
    wait_clk(10);
    check(chan_en == 4'hE, "R2 write via new strap", chan_en, 4'hE);
    strap = old;
    wait_clk(10);
  endtask

  task automatic t_read_nack();
    bit a;
    logic [7:0] v1, v2, v3;
    write_reg(8'h0F);
    check(chan_en == 4'hF, "R10 all channels enabled", chan_en, 4'hF);
    bus_start();
    put_byte(addr_byte(strap, 1), a);
    get_byte(v1, 0);
    get_byte(v2, 1);
    get_byte(v3, 1);
    bus_stop();
    check(v1 == 8'h0F, "R6 first read byte", v1, 8'h0F);
    check(v2 == 8'h0F, "R6 repeated read byte", v2, 8'h0F);
    check(v3 == 8'hFF, "R7 line released after NACK", v3, 8'hFF);
  endtask

  task automatic t_bus_reset_during_ack();
    bit s;
    write_reg(8'h0B);
    bus_start();
    put_byte(addr_byte(strap, 0), s);
    for (int i = 7; i >= 0; i--) put_bit(i == 0 || i == 2);
    sda_m = 1; wait_clk(Q); scl_m = 1; wait_clk(Q);
    check(sda_drive_low, "R8 ack in progress before reset", sda_drive_low, 1);
    bus_rst_n = 0;
    wait_clk(8);
    check(!sda_drive_low, "R8 sda released by bus reset", sda_drive_low, 0);
    check(chan_en == 4'h0, "R8 enables cleared by bus reset", chan_en, 0);
    bus_rst_n = 1;
    wait_clk(Q); scl_m = 0; wait_clk(Q);
    bus_stop();
    wait_clk(10);
    check(chan_en == 4'h0, "R8 staged byte not committed", chan_en, 0);
  endtask

  task automatic t_abort_mid_byte();
    bit a;
    bus_start();
    put_byte(addr_byte(strap, 0), a);
    for (int i = 0; i < 4; i++) put_bit(1);
    bus_start();
    put_byte(addr_byte(strap, 0), a);
    check(a, "R9 address after repeated START", a, 1);
    put_byte(8'h0C, a);
    bus_stop();
    wait_clk(10);
    check(chan_en == 4'hC, "R9 write after repeated START", chan_en, 4'hC);
    bus_start();
    put_byte(addr_byte(strap, 0), a);
    put_byte(8'h03, a);
    put_bit(1); put_bit(1); put_bit(0);
    bus_stop();
    wait_clk(10);
    check(chan_en == 4'h3, "R9 STOP mid-byte keeps last full byte", chan_en, 3);
  endtask

  task automatic t_glitch();
    bit a;
    bus_start();
    put_byte(addr_byte(strap, 0), a);
    sda_m = 0; wait_clk(Q / 2);
    scl_m = 1; wait_clk(1); scl_m = 0;
    wait_clk(Q / 2);
    scl_m = 1; wait_clk(Q);
    sda_m = 1; wait_clk(1); sda_m = 0;
    wait_clk(Q); scl_m = 0; wait_clk(Q);
    for (int i = 6; i >= 0; i--) put_bit(i == 0 || i == 2);
    get_bit(a);
    check(!a, "R12 byte acked despite glitches", a, 0);
    bus_stop();
    wait_clk(10);
    check(chan_en == 4'h5, "R12 glitches ignored", chan_en, 5);
  endtask

  initial begin
    wait_clk(5);
    rst = 0;
    wait_clk(5);
    t_reset();
    t_single_write();
    t_multi_write();
    t_upper_bits();
    t_address_strap();
    t_read_nack();
    t_bus_reset_during_ack();
    t_abort_mid_byte();
    t_glitch();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule